// File: doc/BRIEF.md
# Pin Change Notification Interrupt Unit

This unit watches a group of input pins and raises a single interrupt request whenever an enabled pin changes level. A change can be a rise or a fall. Software chooses the pins it wants to watch by setting bits in two 16-bit enable registers. A second, separate pair of registers holds the per-pin weak pull-up enables, which leave the unit as a vector for the pad ring. The unit synchronizes the pins and keeps a registered copy of the last level it saw. A change is the difference between that copy and the current synchronized level, masked by the enables. Any change sets a sticky flag. Software clears the flag by writing a one to bit 0 of the control word.

The unit must also notice a change while the main clock is stopped in sleep. While the sleep input is high, a combinational compare of the raw pins against the last registered copy drives a wake output, and this path needs no clock edge. When the clock comes back, the normal synchronized path picks up the same difference and sets the flag by the third rising edge. An outside interrupt controller and clock manager use the flag and the wake output. Neither of them is part of this unit.

Register addresses (3-bit address): 0 = enables for pins 15..0, 1 = enables for pins 20..16 in bits 4..0, 2 = pull-ups for pins 15..0, 3 = pull-ups for pins 20..16 in bits 4..0, 4 = control word (bit 0 is the flag on read and the clear on write). Addresses 5 to 7 read as zero and ignore writes.

Top module: `pin_change_notifier`

## Requirements
- R1: After reset, all enable and pull-up bits and the flag are zero. Every address reads zero, and pullupEn and wakeOut are low.
- R2: The enable for pin i is at address 0 bit i when i < 16, and at address 1 bit i-16 when i >= 16. Address 1 bits 15..5 always read zero.
- R3: Suppose the flag is clear and an enabled pin changes level in either direction, with the change applied just after a rising edge. The flag is still low after the second following rising edge and is high after the third.
- R4: A level change on a pin whose enable bit is zero never sets the flag.
- R5: The flag stays set until a write to address 4 with bit 0 = 1. A write with bit 0 = 0 leaves it set. Address 4 bit 0 reads back the flag.
- R6: If a clear write and a detected change land on the same rising edge, the flag stays set.
- R7: Setting an enable bit for a pin whose level changed while it was disabled does not set the flag.
- R8: While sleepMode = 1, wakeOut is high without any clock edge as soon as an enabled pin differs from its last registered level. wakeOut stays low for differences on disabled pins. wakeOut is always low while sleepMode = 0.
- R9: Suppose a change happened while the clock was stopped in sleep. After the clock restarts, the flag is set on the third rising edge, and wakeOut falls at that same edge.
- R10: Addresses 2 and 3 use the same bit map as R2 and drive pullupEn directly. Enable writes never change pullupEn, and pull-up writes never change the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, may be stopped during sleep |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Combinational read data |
| pinIn | input | 21 | Raw pin levels, asynchronous |
| sleepMode | input | 1 | High while the system is in sleep |
| pullupEn | output | 21 | Per-pin weak pull-up enables |
| irqFlag | output | 1 | Sticky change interrupt request |
| wakeOut | output | 1 | Asynchronous wake request during sleep |

## Verification
Suppose the snapshot holds a wrong value. Then a false flag or a missed flag appears on the third edge after the stimulus, and in sleep wakeOut is wrong at once, with no edge needed. A wrong enable or pull-up bit shows in the read-back and in pullupEn straight after the write edge. A bad enable mask shows three edges after a toggle on that pin. The bench sweeps every pin through a rise and a fall with a single enable set, and checks that a disabled neighbour is ignored. It also works through the clear-versus-change collision, the enable-change reload, and a full stopped-clock sleep sequence.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

  typedef enum logic [2:0] {
    REG_EN_LO  = 3'd0,
    REG_EN_HI  = 3'd1,
    REG_PU_LO  = 3'd2,
    REG_PU_HI  = 3'd3,
    REG_CTRL   = 3'd4,
    REG_NONE   = 3'd7
  } pcnReg_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldEnLo;
    logic ldEnHi;
    logic ldPuLo;
    logic ldPuHi;
    logic clrFlag;
  } pcnStrobe_t;

endpackage

// File: rtl/pcn_ctrl.sv
module pcn_ctrl
  import pcn_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic       wrBit0,
  input  logic [2:0] rdAddr,
  output pcnStrobe_t strobe,
  output pcnReg_e    rdSel
);

  pcnReg_e wrSel;

  function automatic pcnReg_e decodeAddr(input logic [2:0] a);
    case (a)
      3'd0:    return REG_EN_LO;
      3'd1:    return REG_EN_HI;
      3'd2:    return REG_PU_LO;
      3'd3:    return REG_PU_HI;
      3'd4:    return REG_CTRL;
      default: return REG_NONE;
    endcase
  endfunction

  always_comb begin
    wrSel = decodeAddr(wrAddr);
    rdSel = decodeAddr(rdAddr);
  end

  always_comb begin
    strobe         = '0;
    strobe.ldEnLo  = wrEn && (wrSel == REG_EN_LO);
    strobe.ldEnHi  = wrEn && (wrSel == REG_EN_HI);
    strobe.ldPuLo  = wrEn && (wrSel == REG_PU_LO);
    strobe.ldPuHi  = wrEn && (wrSel == REG_PU_HI);
    strobe.clrFlag = wrEn && (wrSel == REG_CTRL) && wrBit0;
  end

endmodule

// File: rtl/pcn_datapath.sv
module pcn_datapath
  import pcn_pkg::*;
#(
  parameter int NUM_PINS    = 21,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                sleepMode,
  input  pcnStrobe_t          strobe,
  input  logic [REG_W-1:0]    wrData,
  input  pcnReg_e             rdSel,
  output logic [REG_W-1:0]    rdData,
  output logic [NUM_PINS-1:0] pullupEn,
  output logic                irqFlag,
  output logic                wakeOut,
  output logic                anyChange
);

  localparam int HI_BITS = NUM_PINS - REG_W;

  logic [NUM_PINS-1:0]                  enMask;
  logic [NUM_PINS-1:0]                  puMask;
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncReg;
  logic [NUM_PINS-1:0]                  pinSync;
  logic [NUM_PINS-1:0]                  snapshot;
  logic [NUM_PINS-1:0]                  changeVec;
  logic [REG_W-1:0]                     enLoWord, enHiWord, puLoWord, puHiWord;
  logic                                 unusedWrBits;

  // Per-pin enable and pull-up bits, split across two register words
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pinRegs
    localparam int BANK = i / REG_W;
    localparam int POS  = i % REG_W;
    logic ldEn, ldPu;
    if (BANK == 0) begin : g_lo
      assign ldEn = strobe.ldEnLo;
      assign ldPu = strobe.ldPuLo;
    end else begin : g_hi
      assign ldEn = strobe.ldEnHi;
      assign ldPu = strobe.ldPuHi;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enMask[i] <= 1'b0;
        puMask[i] <= 1'b0;
      end else begin
        if (ldEn) enMask[i] <= wrData[POS];
        if (ldPu) puMask[i] <= wrData[POS];
      end
    end
  end

  // Read words, unmapped positions tie to zero
  for (genvar b = 0; b < REG_W; b++) begin : g_rdWords
    if (b < NUM_PINS) begin : g_lo
      assign enLoWord[b] = enMask[b];
      assign puLoWord[b] = puMask[b];
    end else begin : g_loZero
      assign enLoWord[b] = 1'b0;
      assign puLoWord[b] = 1'b0;
    end
    if (b < HI_BITS) begin : g_hi
      assign enHiWord[b] = enMask[b+REG_W];
      assign puHiWord[b] = puMask[b+REG_W];
    end else begin : g_hiZero
      assign enHiWord[b] = 1'b0;
      assign puHiWord[b] = 1'b0;
    end
  end

  assign unusedWrBits = ^wrData;

  // Input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '0;
    else       syncReg <= {syncReg[SYNC_STAGES-2:0], pinIn};
  end

  assign pinSync = syncReg[SYNC_STAGES-1];

  // Snapshot follows every pin each cycle, so a newly enabled pin
  // always compares against a fresh level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snapshot <= '0;
    else       snapshot <= pinSync;
  end

  assign changeVec = (pinSync ^ snapshot) & enMask;
  assign anyChange = |changeVec;

  // Sticky flag: a change on the clear edge wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlag <= 1'b0;
    else       irqFlag <= (irqFlag && !strobe.clrFlag) || anyChange;
  end

  // Clockless compare of raw pins during sleep
  assign wakeOut = sleepMode && (|((pinIn ^ snapshot) & enMask));

  assign pullupEn = puMask;

  always_comb begin
    case (rdSel)
      REG_EN_LO: rdData = enLoWord;
      REG_EN_HI: rdData = enHiWord;
      REG_PU_LO: rdData = puLoWord;
      REG_PU_HI: rdData = puHiWord;
      REG_CTRL:  rdData = {{(REG_W-1){1'b0}}, irqFlag};
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier
  import pcn_pkg::*;
#(
  parameter int NUM_PINS    = 21,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [2:0]          wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic [2:0]          rdAddr,
  output logic [REG_W-1:0]    rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                sleepMode,
  output logic [NUM_PINS-1:0] pullupEn,
  output logic                irqFlag,
  output logic                wakeOut
);

  pcnStrobe_t strobe;
  pcnReg_e    rdSel;
  logic       anyChange;

  pcn_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBit0 (wrData[0]),
    .rdAddr (rdAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  pcn_datapath #(
    .NUM_PINS    (NUM_PINS),
    .REG_W       (REG_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .sleepMode (sleepMode),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .rdData    (rdData),
    .pullupEn  (pullupEn),
    .irqFlag   (irqFlag),
    .wakeOut   (wakeOut),
    .anyChange (anyChange)
  );

endmodule

// File: rtl/pcn_checker.sv
module pcn_checker #(
  parameter int NUM_PINS = 21
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [2:0]          wrAddr,
  input logic                wrBit0,
  input logic                sleepMode,
  input logic [NUM_PINS-1:0] pullupEn,
  input logic                irqFlag,
  input logic                wakeOut,
  input logic                anyChange
);

  logic clrWrite, enWrite;
  assign clrWrite = wrEn && (wrAddr == 3'd4) && wrBit0;
  assign enWrite  = wrEn && (wrAddr == 3'd0 || wrAddr == 3'd1);

  p_set_on_change_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyChange |=> irqFlag);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqFlag && !anyChange) |=> !irqFlag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !clrWrite) |=> irqFlag);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && !anyChange) |=> !irqFlag);

  p_clear_vs_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrWrite && anyChange) |=> irqFlag);

  p_wake_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode |-> !wakeOut);

  p_pullup_indep_r10: assert property (@(posedge clk) disable iff (!rstN)
    enWrite |=> $stable(pullupEn));

endmodule

bind pin_change_notifier pcn_checker #(.NUM_PINS(NUM_PINS)) u_pcnChecker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrBit0    (wrData[0]),
  .sleepMode (sleepMode),
  .pullupEn  (pullupEn),
  .irqFlag   (irqFlag),
  .wakeOut   (wakeOut),
  .anyChange (anyChange)
);

// File: tb/pin_change_notifier_bench.sv
module pin_change_notifier_bench;

  localparam int NP = 21;

  logic          clk = 1'b0;
  logic          clkRun = 1'b1;
  logic          rstN;
  logic          wrEn;
  logic [2:0]    wrAddr;
  logic [15:0]   wrData;
  logic [2:0]    rdAddr;
  logic [15:0]   rdData;
  logic [NP-1:0] pinIn;
  logic          sleepMode;
  logic [NP-1:0] pullupEn;
  logic          irqFlag;
  logic          wakeOut;

  int checks = 0;
  int fails  = 0;

  pin_change_notifier u_pin_change_notifier (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinIn(pinIn), .sleepMode(sleepMode),
    .pullupEn(pullupEn), .irqFlag(irqFlag), .wakeOut(wakeOut)
  );

  // 50 MHz clock that can be held low for sleep
  initial begin
    forever begin
      #10;
      if (clkRun) clk = ~clk;
      else        clk = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rdAddr = a; #1;
    chk(req, {16'h0, rdData}, {16'h0, exp});
  endtask

  function automatic logic [15:0] loWord(input logic [NP-1:0] m);
    return m[15:0];
  endfunction

  function automatic logic [15:0] hiWord(input logic [NP-1:0] m);
    return {11'h0, m[NP-1:16]};
  endfunction

  task automatic setEnables(input logic [NP-1:0] m);
    wr(3'd0, loWord(m));
    wr(3'd1, hiWord(m));
  endtask

  // Watchdog
  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    pinIn = '0; sleepMode = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rdChk("R1 read", 3'(a), 16'h0);
    chk("R1 pullupEn", 32'(pullupEn), 32'h0);
    chk("R1 flag", 32'(irqFlag), 0);
    chk("R1 wake", 32'(wakeOut), 0);

    // R2 / R10: register map and independence
    setEnables('1);
    rdChk("R2 enable low word", 3'd0, 16'hFFFF);
    rdChk("R2 enable high word", 3'd1, 16'h001F);
    chk("R10 pullups untouched by enables", 32'(pullupEn), 32'h0);
    wr(3'd2, 16'hA5C3);
    wr(3'd3, 16'hFFEA);
    chk("R10 pullupEn map", 32'(pullupEn), 32'({5'h0A, 16'hA5C3}));
    rdChk("R10 pullup high word", 3'd3, 16'h000A);
    rdChk("R10 enables untouched by pullups", 3'd0, 16'hFFFF);
    wr(3'd5, 16'hFFFF);
    rdChk("R2 unmapped write ignored", 3'd0, 16'hFFFF);
    setEnables('0);
    rdChk("R2 cleared high", 3'd1, 16'h0);
    tick(); tick(); tick();
    chk("R4 no flag during config", 32'(irqFlag), 0);

    // Per-pin sweep: R3, R4, R5
    for (int i = 0; i < NP; i++) begin
      logic [NP-1:0] m;
      int j;
      m = '0; m[i] = 1'b1;
      j = (i + 7) % NP;
      setEnables(m);
      rdChk("R2 single enable low", 3'd0, loWord(m));
      rdChk("R2 single enable high", 3'd1, hiWord(m));
      // rising edge on enabled pin
      pinIn[i] = 1'b1;
      tick(); tick();
      chk("R3 rise not early", 32'(irqFlag), 0);
      tick();
      chk("R3 rise sets flag", 32'(irqFlag), 1);
      wr(3'd4, 16'h0000);
      chk("R5 zero write keeps flag", 32'(irqFlag), 1);
      rdChk("R5 flag readback", 3'd4, 16'h0001);
      wr(3'd4, 16'h0001);
      chk("R5 clear", 32'(irqFlag), 0);
      // disabled neighbour toggles
      pinIn[j] = ~pinIn[j];
      tick(); tick(); tick(); tick();
      chk("R4 disabled pin ignored", 32'(irqFlag), 0);
      pinIn[j] = ~pinIn[j];
      tick(); tick(); tick(); tick();
      chk("R4 disabled pin ignored back", 32'(irqFlag), 0);
      // falling edge
      pinIn[i] = 1'b0;
      tick(); tick();
      chk("R3 fall not early", 32'(irqFlag), 0);
      tick();
      chk("R3 fall sets flag", 32'(irqFlag), 1);
      wr(3'd4, 16'h0001);
      chk("R5 clear after fall", 32'(irqFlag), 0);
    end

    // R6: clear and change on the same edge
    begin
      logic [NP-1:0] m;
      m = '0; m[4] = 1'b1;
      setEnables(m);
      pinIn[4] = 1'b1;
      tick(); tick(); tick();
      chk("R6 setup flag", 32'(irqFlag), 1);
      pinIn[4] = 1'b0;
      tick(); tick();
      wrEn = 1'b1; wrAddr = 3'd4; wrData = 16'h0001;
      tick();
      wrEn = 1'b0;
      chk("R6 change beats clear", 32'(irqFlag), 1);
      wr(3'd4, 16'h0001);
      chk("R6 plain clear", 32'(irqFlag), 0);
    end

    // R7: enabling a pin that changed while disabled
    setEnables('0);
    pinIn[18] = 1'b1;
    pinIn[2]  = 1'b1;
    tick(); tick(); tick(); tick();
    begin
      logic [NP-1:0] m;
      m = '0; m[18] = 1'b1; m[2] = 1'b1;
      setEnables(m);
    end
    tick(); tick(); tick(); tick();
    chk("R7 no false flag on enable", 32'(irqFlag), 0);

    // R8: wake gated off while awake
    pinIn[2] = 1'b0;
    #1;
    chk("R8 wake low when awake", 32'(wakeOut), 0);
    tick(); tick(); tick();
    chk("R3 awake change", 32'(irqFlag), 1);
    wr(3'd4, 16'h0001);

    // R8 / R9: stopped-clock sleep
    sleepMode = 1'b1;
    tick();
    clkRun = 1'b0;
    #60;
    chk("R8 wake idle", 32'(wakeOut), 0);
    pinIn[9] = ~pinIn[9];
    #5;
    chk("R8 disabled pin no wake", 32'(wakeOut), 0);
    pinIn[18] = 1'b0;
    #5;
    chk("R8 wake without clock", 32'(wakeOut), 1);
    chk("R9 flag waits for clock", 32'(irqFlag), 0);
    #40;
    clkRun = 1'b1;
    tick();
    chk("R9 edge1", 32'(irqFlag), 0);
    tick();
    chk("R9 edge2", 32'(irqFlag), 0);
    tick();
    chk("R9 edge3 flag", 32'(irqFlag), 1);
    chk("R9 wake drops", 32'(wakeOut), 0);
    sleepMode = 1'b0;
    wr(3'd4, 16'h0001);
    chk("R5 final clear", 32'(irqFlag), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule